// File: doc/BRIEF.md
# Adjacent-Pair Correcting Memory Word Decoder

This block sits on the read path of a protected memory. Each stored word is 22 bits wide: 16 data bits in positions 0 to 15 and 6 check bits in positions 16 to 21. The decoder forms a 6-bit syndrome from a fixed parity-check matrix. It repairs any single flipped bit, and any two flipped bits that sit next to each other. This matters because upsets that strike neighbouring cells tend to disturb a pair of adjacent bits at the same time.

Each data bit has three comparators on the syndrome. The first matches the bit's own column. The second matches the XOR of its column with the column to its left, and the third matches the XOR with the column to its right. If any of the three matches, the bit is inverted. A separate classifier decides whether the syndrome is zero, one of the 43 legal patterns, or none of them. The result is registered, so the decoder has one cycle of latency and a valid strobe travels with the data.

Top module: `secdaec_decoder`

## Requirements
- R1: The parity-check matrix is fixed. Column values are written with syndrome bit 5 first and given in decimal, for positions 0..15: 44,35,11,21,31,49,7,14,50,37,52,27,38,19,45,57. Check position 16+k has a column with only bit 5-k set. The syndrome is the XOR of the columns of all set word bits. All 22 columns and all 21 XORs of adjacent columns are nonzero and pairwise distinct.
- R2: A word with a zero syndrome is delivered with its data bits unchanged, and only the clean flag is set.
- R3: A word with exactly one flipped data bit, at any of the positions 0..15, is delivered with the original data, and only the fixed flag is set.
- R4: A word with two flipped data bits at adjacent positions (i, i+1), for i from 0 to 14, is delivered with the original data, and only the fixed flag is set.
- R5: The boundary pair, data bit 15 together with check bit 16, is corrected back to the original data with the fixed flag set. Data bit 0 is corrected by its own column and by the pair (0,1).
- R6: A word whose flipped bits are all check bits, either a single check bit or two adjacent check bits, is delivered with unchanged data, and only the fixed flag is set.
- R7: A nonzero syndrome that matches none of the 43 legal patterns sets only the uncorrectable flag, and the data is delivered exactly as received.
- R8: out_valid is high in the cycle after each clock edge that samples in_valid high, and low otherwise. While out_valid is high, exactly one of out_clean, out_fixed and out_uncorr is high. While out_valid is low, all three are low.
- R9: A synchronous active-high reset clears out_valid, out_data and all three flags, even when in_valid is high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking in_word as a word to decode |
| in_word | input | 22 | Received word: data in bits 15:0, check bits in 21:16 |
| out_valid | output | 1 | Registered strobe, one cycle after in_valid |
| out_data | output | 16 | Corrected data |
| out_clean | output | 1 | Syndrome was zero |
| out_fixed | output | 1 | Syndrome matched a single or adjacent-pair pattern |
| out_uncorr | output | 1 | Nonzero syndrome matching no legal pattern |

## Verification
Words encoded from three data values (mixed, all zeros and all ones) are sent unmodified, then with every single-bit flip and every adjacent-pair flip across all 22 positions. The all-zero and all-one values separate an inversion that is applied from a bit that is merely forced to a value. Check-only flips show whether the decoder leaves the data alone when the fault lies outside it. Non-adjacent double flips and triple flips whose syndromes fall outside the legal set separate an uncorrectable word from a word that was silently miscorrected. Idle gaps between strobes and a reset asserted while a strobe is present test the registered valid and the flag encoding.

// File: rtl/secdaec_pkg.sv
package secdaec_pkg;

  localparam int DATA_W    = 16;
  localparam int CHK_W     = 6;
  localparam int WORD_W    = DATA_W + CHK_W;
  localparam int NUM_PAIRS = WORD_W - 1;

  typedef logic [CHK_W-1:0]  syn_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic [1:0] {
    VERDICT_CLEAN  = 2'd0,
    VERDICT_FIXED  = 2'd1,
    VERDICT_UNCORR = 2'd2
  } verdict_t;

  // Column of the parity-check matrix for word position idx.
  function automatic syn_t column(input int idx);
    syn_t c;
    if (idx >= DATA_W) begin
      c = syn_t'(1) << (WORD_W - 1 - idx);
    end else begin
      case (idx)
        0:       c = 6'd44;
        1:       c = 6'd35;
        2:       c = 6'd11;
        3:       c = 6'd21;
        4:       c = 6'd31;
        5:       c = 6'd49;
        6:       c = 6'd7;
        7:       c = 6'd14;
        8:       c = 6'd50;
        9:       c = 6'd37;
        10:      c = 6'd52;
        11:      c = 6'd27;
        12:      c = 6'd38;
        13:      c = 6'd19;
        14:      c = 6'd45;
        default: c = 6'd57;
      endcase
    end
    return c;
  endfunction

  // Syndrome produced by flipping positions idx and idx+1 together.
  function automatic syn_t pair_pattern(input int idx);
    return column(idx) ^ column(idx + 1);
  endfunction

  function automatic syn_t syndrome_of(input word_t w);
    syn_t s;
    s = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (w[i]) s = s ^ column(i);
    end
    return s;
  endfunction

endpackage

// File: rtl/sd_syndrome.sv
module sd_syndrome
  import secdaec_pkg::*;
(
  input  word_t word_in,
  output syn_t  syn
);
  always_comb begin
    syn = syndrome_of(word_in);
  end
endmodule

// File: rtl/sd_bit_fix.sv
module sd_bit_fix
  import secdaec_pkg::*;
(
  input  syn_t  syn,
  output data_t fix_mask
);
  // One correction slot per data bit: own column, left pair, right pair.
  for (genvar b = 0; b < DATA_W; b++) begin : g_slot
    logic hit_self;
    logic hit_left;
    logic hit_right;

    assign hit_self  = (syn == column(b));
    assign hit_right = (syn == pair_pattern(b));

    if (b == 0) begin : g_edge
      assign hit_left = 1'b0;
    end else begin : g_inner
      assign hit_left = (syn == pair_pattern(b - 1));
    end

    assign fix_mask[b] = hit_self | hit_left | hit_right;
  end
endmodule

// File: rtl/sd_classify.sv
module sd_classify
  import secdaec_pkg::*;
(
  input  syn_t     syn,
  output logic     syn_zero,
  output logic     syn_known,
  output verdict_t verdict
);
  logic single_hit;
  logic pair_hit;

  always_comb begin
    single_hit = 1'b0;
    pair_hit   = 1'b0;
    for (int i = 0; i < WORD_W; i++) begin
      if (syn == column(i)) single_hit = 1'b1;
    end
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (syn == pair_pattern(p)) pair_hit = 1'b1;
    end
  end

  assign syn_zero  = (syn == '0);
  assign syn_known = single_hit | pair_hit;

  always_comb begin
    if (syn_zero)       verdict = VERDICT_CLEAN;
    else if (syn_known) verdict = VERDICT_FIXED;
    else                verdict = VERDICT_UNCORR;
  end
endmodule

// File: rtl/secdaec_decoder.sv
module secdaec_decoder
  import secdaec_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [WORD_W-1:0]   in_word,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_clean,
  output logic                out_fixed,
  output logic                out_uncorr
);
  syn_t     syn;
  data_t    fix_mask;
  data_t    corrected;
  logic     syn_zero;
  logic     syn_known;
  logic     syn_bad;
  verdict_t verdict;

  sd_syndrome u_syn (
    .word_in (in_word),
    .syn     (syn)
  );

  sd_bit_fix u_fix (
    .syn      (syn),
    .fix_mask (fix_mask)
  );

  sd_classify u_cls (
    .syn       (syn),
    .syn_zero  (syn_zero),
    .syn_known (syn_known),
    .verdict   (verdict)
  );

  assign syn_bad   = (verdict == VERDICT_UNCORR);
  assign corrected = in_word[DATA_W-1:0] ^ fix_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_clean  <= 1'b0;
      out_fixed  <= 1'b0;
      out_uncorr <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      if (in_valid) out_data <= corrected;
      out_clean  <= in_valid && (verdict == VERDICT_CLEAN);
      out_fixed  <= in_valid && (verdict == VERDICT_FIXED);
      out_uncorr <= in_valid && (verdict == VERDICT_UNCORR);
    end
  end

  AST_ZERO_NO_FIX: assert property (@(posedge clk) disable iff (rst)
    syn_zero |-> (fix_mask == '0));                                  // R2
  AST_FIX_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
    (fix_mask != '0) |-> syn_known);                                 // R3
  AST_FIX_AT_MOST_TWO: assert property (@(posedge clk) disable iff (rst)
    $countones(fix_mask) <= 2);                                      // R4
  AST_BAD_NO_FIX: assert property (@(posedge clk) disable iff (rst)
    syn_bad |-> (fix_mask == '0));                                   // R7
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);                                         // R8
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);                                       // R8
  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones({out_clean, out_fixed, out_uncorr}) == 1)); // R8
  AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(out_clean || out_fixed || out_uncorr));         // R8
  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
    in_valid && syn_zero |=> out_data == $past(in_word[DATA_W-1:0])); // R2
  AST_UNCORR_PASS: assert property (@(posedge clk) disable iff (rst)
    in_valid && syn_bad |=> out_data == $past(in_word[DATA_W-1:0])); // R7
endmodule

// File: tb/secdaec_decoder_test.sv
`timescale 1ns/1ps
module secdaec_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [21:0] in_word = '0;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_clean, out_fixed, out_uncorr;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;
  logic exp_v = 1'b0;

  int   cols [22];
  bit   known [64];
  logic [18:0] q_exp [$];
  string       q_req [$];

  localparam logic [2:0] F_CLEAN = 3'b100, F_FIXED = 3'b010, F_UNCORR = 3'b001;

  always #4 clk = ~clk;

  secdaec_decoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_data(out_data),
    .out_clean(out_clean), .out_fixed(out_fixed), .out_uncorr(out_uncorr)
  );

  function automatic logic [21:0] encode(input logic [15:0] d);
    logic [21:0] w;
    w = {6'b0, d};
    for (int r = 0; r < 6; r++) begin
      logic par;
      par = 1'b0;
      for (int i = 0; i < 16; i++) if (d[i] && cols[i][r]) par = ~par;
      w[21 - r] = par;
    end
    return w;
  endfunction

  function automatic int syn_of(input logic [21:0] w);
    int s;
    s = 0;
    for (int i = 0; i < 22; i++) if (w[i]) s = s ^ cols[i];
    return s;
  endfunction

  task automatic check(input string req, input bit ok, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic send(input logic [21:0] w, input logic [15:0] d, input logic [2:0] f,
                      input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    q_exp.push_back({d, f});
    q_req.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(posedge clk) exp_v <= in_valid && !rst;

  // Monitor: scoreboard compare at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        check("R8", out_valid == exp_v,
              $sformatf("out_valid %b expected %b", out_valid, exp_v));
        if (out_valid) begin
          check("R8", {out_clean, out_fixed, out_uncorr} != 3'b000 &&
                      $countones({out_clean, out_fixed, out_uncorr}) == 1,
                $sformatf("flags %b expected one-hot", {out_clean, out_fixed, out_uncorr}));
          if (q_exp.size() == 0) begin
            check("R8", 1'b0, "output with empty scoreboard, expected none");
          end else begin
            logic [18:0] e;
            string r;
            e = q_exp.pop_front();
            r = q_req.pop_front();
            check(r, {out_data, out_clean, out_fixed, out_uncorr} == e,
                  $sformatf("data %h flags %b expected data %h flags %b",
                            out_data, {out_clean, out_fixed, out_uncorr},
                            e[18:3], e[2:0]));
          end
        end else begin
          check("R8", {out_clean, out_fixed, out_uncorr} == 3'b000,
                $sformatf("idle flags %b expected 000", {out_clean, out_fixed, out_uncorr}));
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] vals [3];
    cols = '{44,35,11,21,31,49,7,14,50,37,52,27,38,19,45,57,32,16,8,4,2,1};
    for (int i = 0; i < 64; i++) known[i] = 1'b0;
    for (int i = 0; i < 22; i++) known[cols[i]] = 1'b1;
    for (int i = 0; i < 21; i++) known[cols[i] ^ cols[i+1]] = 1'b1;
    vals = '{16'hA5C3, 16'h0000, 16'hFFFF};

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", {out_valid, out_data, out_clean, out_fixed, out_uncorr} == '0,
          $sformatf("reset state %b_%h_%b expected all zero", out_valid, out_data,
                    {out_clean, out_fixed, out_uncorr}));
    rst = 1'b0;
    mon_on = 1'b1;

    foreach (vals[v]) begin
      logic [15:0] d;
      logic [21:0] w;
      d = vals[v];
      w = encode(d);
      send(w, d, F_CLEAN, "R2 clean word");
      idle(v);
      for (int i = 0; i < 16; i++) begin
        logic [21:0] e;
        e = w;
        e[i] = ~e[i];
        send(e, d, F_FIXED, (i == 0) ? "R5 data bit 0 single" : "R3 single data flip");
      end
      for (int i = 0; i < 15; i++) begin
        logic [21:0] e;
        e = w;
        e[i] = ~e[i];
        e[i+1] = ~e[i+1];
        send(e, d, F_FIXED, (i == 0) ? "R5 pair 0,1" : "R4 adjacent data pair");
      end
      begin
        logic [21:0] e;
        e = w;
        e[15] = ~e[15];
        e[16] = ~e[16];
        send(e, d, F_FIXED, "R5 pair 15,16");
      end
      idle(2);
      for (int i = 16; i < 22; i++) begin
        logic [21:0] e;
        e = w;
        e[i] = ~e[i];
        send(e, d, F_FIXED, "R6 single check flip");
      end
      for (int i = 16; i < 21; i++) begin
        logic [21:0] e;
        e = w;
        e[i] = ~e[i];
        e[i+1] = ~e[i+1];
        send(e, d, F_FIXED, "R6 adjacent check pair");
      end
      // Non-adjacent doubles and triples with syndromes outside the legal set.
      for (int i = 0; i < 19; i++) begin
        logic [21:0] e;
        e = w;
        e[i] = ~e[i];
        e[i+2] = ~e[i+2];
        if (!known[syn_of(e)]) send(e, e[15:0], F_UNCORR, "R7 gap-2 double");
        e[i+3] = ~e[i+3];
        if (syn_of(e) != 0 && !known[syn_of(e)])
          send(e, e[15:0], F_UNCORR, "R7 triple");
      end
      idle(1);
    end

    // R1: a further spread of encoded words must decode clean.
    for (int k = 0; k < 8; k++) begin
      logic [15:0] d;
      d = 16'h1357 * 16'(k + 1) ^ 16'h8001;
      send(encode(d), d, F_CLEAN, "R1 encoder agreement");
    end
    idle(3);

    // R9: reset while a strobe is present produces nothing.
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    in_word = encode(16'hBEEF) ^ 22'h1;
    @(negedge clk);
    check("R9", {out_valid, out_data, out_clean, out_fixed, out_uncorr} == '0,
          $sformatf("state under reset %b_%h_%b expected all zero", out_valid, out_data,
                    {out_clean, out_fixed, out_uncorr}));
    rst = 1'b0;
    in_valid = 1'b0;
    idle(3);

    check("R8", q_exp.size() == 0,
          $sformatf("scoreboard left %0d expected 0", q_exp.size()));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule